// File: doc/BRIEF.md
# Selectable-Owner Clock Gate Controller

This block controls a set of gated copies of one reference clock. Each gate has a small control word. A select field hands ownership of the gate either to software or to an external hardware request line. In software mode an enable field switches the clock on or off. In hardware mode the request line, brought through a synchronizer, decides the gate state, and the enable field is ignored.

A read-only status field reports the gate's settled state after a fixed synchronizer delay. Software therefore writes the control word and then polls status until it matches the state it asked for. Gates marked keep-on at build time cannot be stopped from software: in software mode they run whatever the enable field holds. Gating is glitch-free. The enable is latched while the reference clock is low and ANDed with the clock.

Top module: `hsw_clk_gate_ctrl`

## Requirements
- R1: Control word layout: bit 0 is the software enable (read/write). Bit 1 is the owner select, where 1 means hardware and 0 means software (read/write). Bit 2 is status (read-only; written values are discarded). Bits above 2 always read 0 and ignore writes.
- R2: After reset every gate reads 0 (software owner, enable clear), and every gate that is not keep-on produces no clock pulses.
- R3: In software mode, a control write sampled at rising edge k makes the gated clock start or stop with the high phase that begins at edge k+2.
- R4: In hardware mode, a change of hw_req_i sampled at edge k appears on the gated clock with the high phase that begins at edge k+SYNC_STAGES+1. The enable field has no effect on the gate in this mode.
- R5: A gate whose KEEP_ON_MASK bit is set runs in software mode whatever the enable field holds, including straight after reset.
- R6: Status lags the gate state by SYNC_STAGES edges. After a software write at edge k it reads the new state after edge k+SYNC_STAGES+1. After a hardware request change at edge k it reads the new state after edge k+2*SYNC_STAGES.
- R7: The gated clock is low during every low phase of clk_i. The enable that governs a high phase is fixed before that phase begins.
- R8: Status equals the requested gate state at most 2*SYNC_STAGES+1 edges after the request last changed. Elaboration rejects any configuration where four times this bound exceeds POLL_CYCLES.
- R9: A write changes only the gate addressed by wr_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, also the clock being gated |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for a control word |
| wr_idx_i | input | IDX_W | Gate addressed by the write |
| wr_data_i | input | REG_W | Write data (bits 1:0 used) |
| rd_idx_i | input | IDX_W | Gate whose control word is read |
| rd_data_o | output | REG_W | Control word of the selected gate, zero-extended |
| hw_req_i | input | N_GATES | Per-gate hardware run request, asynchronous |
| gclk_o | output | N_GATES | Gated clocks |

## Verification
A software write sampled at edge k is due on the gated clock at edge k+2 and on status after edge k+SYNC_STAGES+1. A hardware request change is due on the gated clock at edge k+SYNC_STAGES+1 and on status after edge k+2*SYNC_STAGES. Directed sequences check the cycle before and the cycle of each of these edges. Inputs are driven and outputs sampled 5 ns after a rising edge. The gated clock is read once in the high phase and once in the low phase. Random phases hold each stimulus for 2*SYNC_STAGES edges before checking every gate, so each check falls inside the R8 bound.

// File: rtl/hsw_gate_pkg.sv
package hsw_gate_pkg;

   // Number of meaningful bits in one control word
   localparam int unsigned FIELD_W = 3;

   // Packed order fixes the bit positions software decodes:
   // bit 2 status, bit 1 owner select (1 = hardware), bit 0 software enable
   typedef struct packed {
      logic status;
      logic hw_sel;
      logic sw_en;
   } gate_reg_t;

   // Requested gate state for one gate
   function automatic logic gate_target(input logic hw_sel,
                                        input logic sw_en,
                                        input logic hw_req,
                                        input logic keep_on);
      return hw_sel ? hw_req : (sw_en | keep_on);
   endfunction

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("hsw_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsw_gate_cell.sv
module hsw_gate_cell (
   input  logic clk_i,
   input  logic en_i,
   output logic held_o,
   output logic gclk_o
);

   logic held;

   // Transparent only while the clock is low, so the enable cannot
   // change during a high phase
   always_latch begin
      if (!clk_i) held <= en_i;
   end

   assign held_o = held;
   assign gclk_o = clk_i & held;

endmodule

// File: rtl/hsw_gate_slice.sv
module hsw_gate_slice
   import hsw_gate_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          KEEP_ON     = 1'b0
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      wr_i,
   input  logic      wr_hw_sel_i,
   input  logic      wr_sw_en_i,
   input  logic      hw_req_i,
   output gate_reg_t reg_o,
   output logic      req_s_o,
   output logic      gate_o,
   output logic      held_o,
   output logic      gclk_o
);

   logic hw_sel_q;
   logic sw_en_q;
   logic req_sync;
   logic target;
   logic gate_q;
   logic status_s;

   // Control fields
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hw_sel_q <= 1'b0;
         sw_en_q  <= 1'b0;
      end else if (wr_i) begin
         hw_sel_q <= wr_hw_sel_i;
         sw_en_q  <= wr_sw_en_i;
      end
   end

   // Hardware request crosses in from an unrelated source
   hsw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (hw_req_i),
      .q_o   (req_sync)
   );

   assign target = gate_target(hw_sel_q, sw_en_q, req_sync, KEEP_ON);

   // Registered gate state: a keep-on gate comes out of reset running
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= KEEP_ON;
      else         gate_q <= target;
   end

   hsw_gate_cell u_cell (
      .clk_i (clk_i),
      .en_i  (gate_q),
      .held_o(held_o),
      .gclk_o(gclk_o)
   );

   // Status confirms the gate state through the same stage count
   hsw_sync #(.STAGES(SYNC_STAGES)) u_stat_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (gate_q),
      .q_o   (status_s)
   );

   assign reg_o   = '{status: status_s, hw_sel: hw_sel_q, sw_en: sw_en_q};
   assign req_s_o = req_sync;
   assign gate_o  = gate_q;

endmodule

// File: rtl/hsw_clk_gate_ctrl.sv
module hsw_clk_gate_ctrl
   import hsw_gate_pkg::*;
#(
   parameter int unsigned          N_GATES      = 4,
   parameter int unsigned          SYNC_STAGES  = 2,
   parameter int unsigned          REG_W        = 8,
   parameter int unsigned          POLL_CYCLES  = 2000,
   parameter logic [N_GATES-1:0]   KEEP_ON_MASK = '0,
   localparam int unsigned         IDX_W        = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [REG_W-1:0]   wr_data_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [REG_W-1:0]   rd_data_o,
   input  logic [N_GATES-1:0] hw_req_i,
   output logic [N_GATES-1:0] gclk_o
);

   localparam int unsigned SETTLE_LIMIT = 2 * SYNC_STAGES + 1;

   generate
      if (N_GATES < 1) begin : g_bad_count
         $error("hsw_clk_gate_ctrl: N_GATES must be at least 1");
      end
      if (REG_W < FIELD_W) begin : g_bad_width
         $error("hsw_clk_gate_ctrl: REG_W too narrow for the control word");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("hsw_clk_gate_ctrl: SYNC_STAGES must be at least 1");
      end
      if (4 * SETTLE_LIMIT > POLL_CYCLES) begin : g_bad_settle
         $error("hsw_clk_gate_ctrl: settle time not well inside the polling budget");
      end
   endgenerate

   gate_reg_t          regs [N_GATES];
   logic [N_GATES-1:0] hw_sel_v;
   logic [N_GATES-1:0] sw_en_v;
   logic [N_GATES-1:0] status_v;
   logic [N_GATES-1:0] req_sync_v;
   logic [N_GATES-1:0] gate_v;
   logic [N_GATES-1:0] held_v;
   logic [REG_W-3:0]   unused_wr_bits;

   assign unused_wr_bits = wr_data_i[REG_W-1:2];

   generate
      for (genvar gi = 0; gi < N_GATES; gi++) begin : g_gate
         logic hit;
         assign hit = wr_en_i && (wr_idx_i == IDX_W'(gi));

         hsw_gate_slice #(
            .SYNC_STAGES(SYNC_STAGES),
            .KEEP_ON    (KEEP_ON_MASK[gi])
         ) u_slice (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .wr_i       (hit),
            .wr_hw_sel_i(wr_data_i[1]),
            .wr_sw_en_i (wr_data_i[0]),
            .hw_req_i   (hw_req_i[gi]),
            .reg_o      (regs[gi]),
            .req_s_o    (req_sync_v[gi]),
            .gate_o     (gate_v[gi]),
            .held_o     (held_v[gi]),
            .gclk_o     (gclk_o[gi])
         );

         assign hw_sel_v[gi] = regs[gi].hw_sel;
         assign sw_en_v[gi]  = regs[gi].sw_en;
         assign status_v[gi] = regs[gi].status;
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < N_GATES; i++) begin
         if (rd_idx_i == IDX_W'(i)) rd_data_o = REG_W'(regs[i]);
      end
   end

endmodule

// File: rtl/hsw_gate_chk.sv
module hsw_gate_chk #(
   parameter int unsigned        N_GATES      = 4,
   parameter int unsigned        SYNC_STAGES  = 2,
   parameter logic [N_GATES-1:0] KEEP_ON_MASK = '0
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [N_GATES-1:0] hw_req_i,
   input logic [N_GATES-1:0] hw_sel_v,
   input logic [N_GATES-1:0] sw_en_v,
   input logic [N_GATES-1:0] req_sync_v,
   input logic [N_GATES-1:0] gate_v,
   input logic [N_GATES-1:0] held_v,
   input logic [N_GATES-1:0] status_v
);

   localparam int unsigned LIMIT = 2 * SYNC_STAGES + 1;
   localparam int unsigned CW    = $clog2(LIMIT + 2);

   generate
      for (genvar g = 0; g < N_GATES; g++) begin : g_chk
         logic          want;
         logic          want_q;
         logic [CW-1:0] wait_q;

         assign want = hw_sel_v[g] ? hw_req_i[g] : (sw_en_v[g] | KEEP_ON_MASK[g]);

         // Cycles since the request last changed with status still differing
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               want_q <= 1'b0;
               wait_q <= '0;
            end else begin
               want_q <= want;
               if (status_v[g] == want || want != want_q) wait_q <= '0;
               else if (wait_q != {CW{1'b1}})             wait_q <= wait_q + 1'b1;
            end
         end

         if (KEEP_ON_MASK[g]) begin : g_keep
            p_keep_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
               $past(!hw_sel_v[g]) |-> gate_v[g]);
         end else begin : g_plain
            p_sw_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
               ($past(!hw_sel_v[g]) && $past(!sw_en_v[g])) |-> !gate_v[g]);
         end

         p_sw_on_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(!hw_sel_v[g]) && $past(sw_en_v[g])) |-> gate_v[g]);

         p_hw_ignores_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(hw_sel_v[g]) && hw_sel_v[g] && $stable(req_sync_v[g]))
            |=> $stable(gate_v[g]));

         p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            held_v[g] == gate_v[g]);

         p_settle_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            wait_q <= CW'(LIMIT));
      end
   endgenerate

endmodule

bind hsw_clk_gate_ctrl hsw_gate_chk #(
   .N_GATES     (N_GATES),
   .SYNC_STAGES (SYNC_STAGES),
   .KEEP_ON_MASK(KEEP_ON_MASK)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .hw_req_i  (hw_req_i),
   .hw_sel_v  (hw_sel_v),
   .sw_en_v   (sw_en_v),
   .req_sync_v(req_sync_v),
   .gate_v    (gate_v),
   .held_v    (held_v),
   .status_v  (status_v)
);

// File: tb/hsw_clk_gate_ctrl_bench.sv
module hsw_clk_gate_ctrl_bench;

   localparam int unsigned N    = 4;
   localparam int unsigned S    = 2;
   localparam int unsigned RW   = 8;
   localparam int unsigned IW   = 2;
   localparam logic [N-1:0] KEEP = 4'b1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [RW-1:0] wr_data = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [RW-1:0] rd_data;
   logic [N-1:0]  hw_req = '0;
   logic [N-1:0]  gclk;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   bit           m_sel [N];
   bit           m_en  [N];
   logic [N-1:0] m_req = '0;

   always #10 clk = ~clk;

   hsw_clk_gate_ctrl #(
      .N_GATES     (N),
      .SYNC_STAGES (S),
      .REG_W       (RW),
      .KEEP_ON_MASK(KEEP)
   ) u_hsw_clk_gate_ctrl (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .wr_en_i  (wr_en),
      .wr_idx_i (wr_idx),
      .wr_data_i(wr_data),
      .rd_idx_i (rd_idx),
      .rd_data_o(rd_data),
      .hw_req_i (hw_req),
      .gclk_o   (gclk)
   );

   function automatic bit exp_on(int g);
      return m_sel[g] ? m_req[g] : (m_en[g] | KEEP[g]);
   endfunction

   function automatic logic [RW-1:0] exp_word(int g);
      return {5'b0, exp_on(g), m_sel[g], m_en[g]};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic wr(int g, logic [RW-1:0] d);
      wr_idx  = IW'(g);
      wr_data = d;
      wr_en   = 1'b1;
      tick();
      wr_en   = 1'b0;
      m_sel[g] = d[1];
      m_en[g]  = d[0];
   endtask

   task automatic rd(int g, output logic [RW-1:0] v);
      rd_idx = IW'(g);
      #1;
      v = rd_data;
   endtask

   // Called 5 ns after a rising edge: compares every gate against the model
   task automatic check_all(string tag);
      logic [N-1:0]  hi;
      logic [N-1:0]  lo;
      logic [RW-1:0] v;
      hi = gclk;
      #8;
      lo = gclk;
      for (int g = 0; g < N; g++) begin
         check($sformatf("%s %s gate%0d high phase", tag, m_sel[g] ? "R4" : "R3", g),
               32'(hi[g]), 32'(exp_on(g)));
         check($sformatf("%s R7 gate%0d low phase", tag, g), 32'(lo[g]), 32'd0);
         rd(g, v);
         check($sformatf("%s R8 R9 gate%0d word", tag, g), 32'(v), 32'(exp_word(g)));
      end
   endtask

   task automatic settle();
      repeat (2 * S + 1) tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [RW-1:0] v;
      for (int g = 0; g < N; g++) begin
         m_sel[g] = 1'b0;
         m_en[g]  = 1'b0;
      end
      void'($urandom(32'h5EED_0421));

      // R2: reset state
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      for (int g = 0; g < N - 1; g++) begin
         rd(g, v);
         check($sformatf("R2 gate%0d word after reset", g), 32'(v), 32'd0);
      end
      tick();
      check("R2 plain gates idle after reset", 32'(gclk[N-2:0]), 32'd0);

      // R5: keep-on gate runs from reset
      settle();
      check_all("R5 after reset");

      // R3 / R6: software enable latency on gate 0
      wr(0, 8'h01);                      // sampled at edge 0
      tick();
      check("R3 gate0 not yet running at edge 1", 32'(gclk[0]), 32'd0);
      tick();
      check("R3 gate0 running at edge 2", 32'(gclk[0]), 32'd1);
      rd(0, v);
      check("R6 gate0 status still low at edge 2", 32'(v), 32'h01);
      tick();
      rd(0, v);
      check("R6 gate0 status high at edge 3", 32'(v), 32'h05);

      // R3: software disable latency on gate 0
      wr(0, 8'h00);
      tick();
      check("R3 gate0 still running at edge 1", 32'(gclk[0]), 32'd1);
      tick();
      check("R3 gate0 stopped at edge 2", 32'(gclk[0]), 32'd0);
      settle();

      // R1: field positions, status and upper bits not writable
      wr(1, 8'hFC);
      rd(1, v);
      check("R1 gate1 only low two bits stored", 32'(v), 32'h00);
      wr(1, 8'hFD);
      rd(1, v);
      check("R1 gate1 enable stored, status write ignored", 32'(v), 32'h01);
      settle();
      check_all("R1 after enable");

      // R5: keep-on gate ignores a cleared enable
      wr(3, 8'h00);
      settle();
      check_all("R5 enable cleared");
      wr(3, 8'h01);
      settle();
      check_all("R5 enable set");

      // R4 / R6: hardware request latency on gate 2
      wr(2, 8'h02);
      settle();
      check_all("R4 hw mode request low");
      hw_req[2] = 1'b1;                  // sampled at edge 0
      m_req[2]  = 1'b1;
      tick();
      tick();
      tick();
      check("R4 gate2 not yet running at edge 2", 32'(gclk[2]), 32'd0);
      tick();
      check("R4 gate2 running at edge 3", 32'(gclk[2]), 32'd1);
      rd(2, v);
      check("R6 gate2 status still low at edge 3", 32'(v), 32'h02);
      tick();
      rd(2, v);
      check("R6 gate2 status high at edge 4", 32'(v), 32'h06);

      // R4: enable field has no effect in hardware mode
      hw_req[2] = 1'b0;
      m_req[2]  = 1'b0;
      settle();
      wr(2, 8'h03);
      settle();
      check_all("R4 enable set in hw mode");
      hw_req[2] = 1'b1;
      m_req[2]  = 1'b1;
      wr(2, 8'h02);
      settle();
      check_all("R4 enable cleared in hw mode");

      // Random mix of writes and request changes
      for (int it = 0; it < 300; it++) begin
         logic [N-1:0] req;
         req    = N'($urandom);
         hw_req = req;
         m_req  = req;
         if ($urandom_range(0, 3) == 0) begin
            tick();
         end else begin
            wr($urandom_range(0, N - 1), RW'($urandom));
         end
         repeat (2 * S) tick();
         check_all($sformatf("random %0d", it));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule